// File: doc/BRIEF.md
# Prime-Count Interleaved Word Memory

This block is a word-addressed storage array split across a prime number of banks, each bank holding a power-of-two number of words. The bank that owns a word is the remainder of the word address divided by the bank count. The slot inside that bank is the remainder of the address divided by the bank depth. Because the depth is a power of two, that slot is simply the low address bits. A prime bank count and a power-of-two depth share no factor, so each legal address lands on its own bank/slot pair. A power-of-two stride therefore walks through every bank instead of hammering one.

Requests arrive one at a time on a single port that carries an address, write data and a read/write select. Each accepted request produces a one-cycle response on the following cycle. A bank that has just been accessed stays occupied for a programmable number of cycles, which models its access time. A request aimed at an occupied bank is held off through a ready signal. Addresses beyond the populated space are answered with an error and leave the storage alone.

The remainder by the bank count is formed combinationally by a bit-serial reduction unrolled over the address width. The path needs no divider.

Top module: `primebank_mem`

## Requirements
- R1: `map_bank` equals `req_addr` modulo BANKS (default 3) for every in-range address, e.g. address 8 gives bank 2 and address 9 gives bank 0.
- R2: `map_offset` equals the low DEPTH_LOG2 bits of `req_addr` (address modulo 2^DEPTH_LOG2, default 8), e.g. address 9 gives offset 1.
- R3: Over addresses 0 to BANKS*DEPTH-1 every (bank, offset) pair occurs exactly once.
- R4: A read returns the data most recently written to the same address; writes to one address never change any other address.
- R5: A request accepted at a clock edge (`req_valid` and `req_ready` high) yields `rsp_valid` high for exactly the cycle after that edge. `rsp_valid` stays low when nothing was accepted.
- R6: After an in-range access is accepted with `busy_cycles` = K, `req_ready` is low for a request to the same bank during the next K cycles and high again afterwards.
- R7: An occupied bank does not hold off requests whose address maps to a different bank.
- R8: An address at or above BANKS*DEPTH is always accepted at once. It returns `rsp_err` = 1 with `rsp_rdata` = 0, changes no stored word and occupies no bank.
- R9: After reset `rsp_valid` is 0, `req_ready` is 1 and every word reads as 0.
- R10: With `busy_cycles` = 0, back-to-back requests to the same bank are accepted with no stall.
- R11: A write response carries `rsp_rdata` = 0 and `rsp_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| busy_cycles | input | BUSY_W | Cycles a bank stays occupied after an access |
| req_ready | output | 1 | Target bank free; request accepted when valid is also high |
| map_bank | output | BANK_W | Bank selected by the current address |
| map_offset | output | DEPTH_LOG2 | Slot inside the selected bank |
| rsp_valid | output | 1 | Response for the request accepted on the previous edge |
| rsp_err | output | 1 | Response belongs to an out-of-range address |
| rsp_rdata | output | DATA_W | Read data (0 for writes and errors) |

## Verification
The bench goes after the seam between banks. It checks addresses 8 and 9, where the bank wraps while the slot does not. It also checks that every legal address has a distinct pair. A mapper that used the low bits for the bank, or dropped a carry in the reduction, would alias two addresses and corrupt data. That shows up as a repeated pair or a wrong read-back. The bench measures stall length exactly at K cycles and at K = 0. This catches off-by-one busy counters and counters shared across banks. It also writes to addresses just past the top. An error path that still wrote through the truncated slot would change a legal word that the bench reads back.

// File: rtl/primebank_pkg.sv
package primebank_pkg;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

    typedef struct packed {
        logic vld;
        logic err;
        logic rd;
    } rsp_flags_t;

    // one step of a shift-and-subtract remainder: r < p on entry and exit
    function automatic int unsigned mod_step(int unsigned r, logic b, int unsigned p);
        int unsigned t;
        t = 2 * r + (b ? 32'd1 : 32'd0);
        return (t >= p) ? (t - p) : t;
    endfunction

    function automatic int unsigned width_of(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/primebank_map.sv
module primebank_map #(
    parameter int unsigned BANKS      = 3,
    parameter int unsigned DEPTH_LOG2 = 3,
    parameter int unsigned ADDR_W     = 6,
    localparam int unsigned BANK_W    = primebank_pkg::width_of(BANKS),
    localparam int unsigned TOTAL     = BANKS * (1 << DEPTH_LOG2)
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic [BANK_W-1:0]     bank,
    output logic [DEPTH_LOG2-1:0] offset,
    output logic                  out_of_range
);
    int unsigned rem;

    // remainder by the bank count, MSB first, no divider
    always_comb begin
        rem = 0;
        for (int i = ADDR_W - 1; i >= 0; i--) begin
            rem = primebank_pkg::mod_step(rem, addr[i], BANKS);
        end
        bank = BANK_W'(rem);
    end

    // depth is a power of two: the slot is the low address bits
    assign offset       = addr[DEPTH_LOG2-1:0];
    assign out_of_range = (32'(addr) >= TOTAL);

endmodule

// File: rtl/primebank_bank.sv
module primebank_bank #(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned DEPTH_LOG2 = 3,
    parameter int unsigned BUSY_W     = 4,
    localparam int unsigned DEPTH     = 1 << DEPTH_LOG2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sel,
    input  logic                  we,
    input  logic [DEPTH_LOG2-1:0] slot,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [BUSY_W-1:0]     hold_len,
    output logic [DATA_W-1:0]     rdata,
    output logic                  busy
);
    logic [DATA_W-1:0] store [DEPTH];
    logic [BUSY_W-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) store[i] <= '0;
            rdata <= '0;
        end else if (sel) begin
            if (we) store[slot] <= wdata;
            else    rdata       <= store[slot];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                 hold_cnt <= '0;
        else if (sel)            hold_cnt <= hold_len;
        else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
    end

    assign busy = (hold_cnt != '0);

    AST_BUSY_NO_SELECT: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sel); // R6
    AST_HOLD_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
        (busy && !sel) |=> (hold_cnt == $past(hold_cnt) - 1'b1)); // R6

endmodule

// File: rtl/primebank_mem.sv
module primebank_mem #(
    parameter int unsigned BANKS      = 3,
    parameter int unsigned DEPTH_LOG2 = 3,
    parameter int unsigned ADDR_W     = 6,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned BUSY_W     = 4,
    localparam int unsigned BANK_W    = primebank_pkg::width_of(BANKS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [BUSY_W-1:0]     busy_cycles,
    output logic                  req_ready,
    output logic [BANK_W-1:0]     map_bank,
    output logic [DEPTH_LOG2-1:0] map_offset,
    output logic                  rsp_valid,
    output logic                  rsp_err,
    output logic [DATA_W-1:0]     rsp_rdata
);
    import primebank_pkg::*;

    op_e                op;
    logic               oor;
    logic               accept;
    logic [BANKS-1:0]   bank_busy;
    logic [BANKS-1:0]   bank_sel;
    logic [DATA_W-1:0]  bank_rd [BANKS];
    rsp_flags_t         pend;
    logic [BANK_W-1:0]  pend_bank;

    assign op = op_e'(req_write);

    primebank_map #(
        .BANKS(BANKS), .DEPTH_LOG2(DEPTH_LOG2), .ADDR_W(ADDR_W)
    ) u_map (
        .addr(req_addr), .bank(map_bank), .offset(map_offset), .out_of_range(oor)
    );

    assign req_ready = oor | ~bank_busy[map_bank];
    assign accept    = req_valid & req_ready;

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        assign bank_sel[g] = accept & ~oor & (map_bank == BANK_W'(g));
        primebank_bank #(
            .DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2), .BUSY_W(BUSY_W)
        ) u_bank (
            .clk(clk), .rst(rst), .sel(bank_sel[g]), .we(op == OP_WRITE),
            .slot(map_offset), .wdata(req_wdata), .hold_len(busy_cycles),
            .rdata(bank_rd[g]), .busy(bank_busy[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= '0;
            pend_bank <= '0;
        end else begin
            pend.vld  <= accept;
            pend.err  <= accept & oor;
            pend.rd   <= accept & ~oor & (op == OP_READ);
            pend_bank <= map_bank;
        end
    end

    assign rsp_valid = pend.vld;
    assign rsp_err   = pend.err;
    assign rsp_rdata = pend.rd ? bank_rd[pend_bank] : '0;

    AST_BANK_BELOW_COUNT: assert property (@(posedge clk) disable iff (rst)
        !oor |-> (32'(map_bank) < BANKS)); // R1
    AST_ONE_BANK_SELECTED: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_sel)); // R3
    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |=> rsp_valid); // R5
    AST_NO_RSP_WITHOUT_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !rsp_valid); // R5
    AST_OOR_NEVER_STALLS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && oor) |-> req_ready); // R8
    AST_ERR_HAS_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_rdata == '0)); // R8

endmodule

// File: tb/primebank_mem_bench.sv
module primebank_mem_bench;
    localparam int BANKS = 3;
    localparam int DLOG  = 3;
    localparam int DEPTH = 1 << DLOG;
    localparam int TOTAL = BANKS * DEPTH;
    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int BW    = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr  = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [BW-1:0] busy_cycles = '0;
    logic          req_ready;
    logic [1:0]    map_bank;
    logic [DLOG-1:0] map_offset;
    logic          rsp_valid;
    logic          rsp_err;
    logic [DW-1:0] rsp_rdata;

    int total = 0;
    int bad   = 0;
    logic [DW-1:0] model [TOTAL];

    always #10 clk = ~clk;

    primebank_mem #(.BANKS(BANKS), .DEPTH_LOG2(DLOG), .ADDR_W(AW),
                    .DATA_W(DW), .BUSY_W(BW)) u_primebank_mem (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy_cycles(busy_cycles),
        .req_ready(req_ready), .map_bank(map_bank), .map_offset(map_offset),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_req(input bit wr, input int addr, input logic [DW-1:0] d,
                          output int stalls, output logic [DW-1:0] rd, output bit err);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = AW'(addr); req_wdata = d;
        stalls = 0;
        #1;
        while (!req_ready) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        check(rsp_valid == 1'b1, "R5 rsp_valid after accept", int'(rsp_valid), 1);
        rd  = rsp_rdata;
        err = rsp_err;
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int st;
        logic [DW-1:0] rd;
        bit er;
        bit used [TOTAL];
        for (int i = 0; i < TOTAL; i++) begin used[i] = 1'b0; model[i] = '0; end
        void'($urandom(32'd2024));

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R9 reset state
        check(rsp_valid == 1'b0, "R9 rsp_valid after reset", int'(rsp_valid), 0);
        check(req_ready == 1'b1, "R9 req_ready after reset", int'(req_ready), 1);
        do_req(1'b0, 5, '0, st, rd, er);
        check(rd == '0, "R9 word reads zero after reset", int'(rd), 0);
        @(posedge clk); #1;
        check(rsp_valid == 1'b0, "R5 rsp_valid single cycle", int'(rsp_valid), 0);

        // R1 R2 R3 address walk
        for (int a = 0; a < TOTAL; a++) begin
            @(negedge clk); req_addr = AW'(a); #1;
            check(int'(map_bank) == a % BANKS, "R1 bank mapping", int'(map_bank), a % BANKS);
            check(int'(map_offset) == a % DEPTH, "R2 offset mapping", int'(map_offset), a % DEPTH);
            if (int'(map_bank) < BANKS) begin
                check(!used[int'(map_bank) * DEPTH + int'(map_offset)], "R3 pair unique",
                      a, -1);
                used[int'(map_bank) * DEPTH + int'(map_offset)] = 1'b1;
            end
        end
        // R1 R2 directed seam addresses
        @(negedge clk); req_addr = 6'd8; #1;
        check(map_bank == 2'd2 && map_offset == 3'd0, "R1 address 8", int'(map_bank), 2);
        @(negedge clk); req_addr = 6'd9; #1;
        check(map_bank == 2'd0 && map_offset == 3'd1, "R2 address 9", int'(map_offset), 1);

        // R10 no stall with zero busy length, R11 write response
        busy_cycles = 4'd0;
        do_req(1'b1, 0, 16'h1111, st, rd, er); model[0] = 16'h1111;
        check(rd == '0 && !er, "R11 write response data", int'(rd), 0);
        do_req(1'b1, 3, 16'h3333, st, rd, er); model[3] = 16'h3333;
        check(st == 0, "R10 same bank back to back", st, 0);

        // R6 exact stall length, R7 other bank unaffected
        busy_cycles = 4'd3;
        do_req(1'b0, 0, '0, st, rd, er);
        check(rd == 16'h1111, "R4 read back addr 0", int'(rd), 16'h1111);
        do_req(1'b0, 1, '0, st, rd, er);
        check(st == 0, "R7 other bank free", st, 0);
        do_req(1'b0, 3, '0, st, rd, er);
        check(st == 2, "R6 stall for remaining busy cycles", st, 2);
        check(rd == 16'h3333, "R4 read back addr 3", int'(rd), 16'h3333);
        do_req(1'b0, 6, '0, st, rd, er);
        check(st == 3, "R6 stall equals busy length", st, 3);

        // R8 out of range: err, no write, no stall
        busy_cycles = 4'd5;
        do_req(1'b1, 6, 16'hABCD, st, rd, er); model[6] = 16'hABCD;
        do_req(1'b1, 30, 16'h5555, st, rd, er);
        check(er == 1'b1, "R8 error flag", int'(er), 1);
        check(st == 0, "R8 no stall", st, 0);
        do_req(1'b0, 63, '0, st, rd, er);
        check(er == 1'b1 && rd == '0, "R8 read error data", int'(rd), 0);
        busy_cycles = 4'd0;
        repeat (6) @(posedge clk);
        do_req(1'b0, 6, '0, st, rd, er);
        check(rd == 16'hABCD && !er, "R8 storage untouched", int'(rd), 16'hABCD);

        // R4 R8 random mix against model
        for (int n = 0; n < 400; n++) begin
            int a;
            bit w;
            logic [DW-1:0] d;
            a = int'($urandom_range(0, 40));
            w = 1'($urandom_range(0, 1));
            d = DW'($urandom);
            busy_cycles = BW'($urandom_range(0, 3));
            do_req(w, a, d, st, rd, er);
            if (a >= TOTAL) begin
                check(er == 1'b1 && rd == '0, "R8 random out of range", int'(er), 1);
            end else if (w) begin
                model[a] = d;
                check(!er && rd == '0, "R11 random write response", int'(rd), 0);
            end else begin
                check(!er && rd == model[a], "R4 random read", int'(rd), int'(model[a]));
            end
        end

        busy_cycles = 4'd0;
        for (int a = 0; a < TOTAL; a++) begin
            do_req(1'b0, a, '0, st, rd, er);
            check(rd == model[a], "R4 final sweep", int'(rd), int'(model[a]));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule